// File: doc/BRIEF.md
# NOR Flash Word-Program and Sector-Erase Sequencer

This block drives a 16-bit NOR flash through its command protocol, so the host only states what it wants done. The host issues one of two requests. A program request carries a word address and a data word. An erase request carries a first and a last sector index, which are signed. A vector of per-sector protection bits travels with each erase request. The block writes the unlock and command words itself, watches bit 7 of the flash read data to detect completion, and finishes with a one-cycle `done` pulse and a two-bit result code.

Before it programs a word, the block reads the word and refuses the request when any bit would have to rise from 0 to 1. An erase uses a single unlock preamble, then starts every unprotected sector in the range in ascending order. It waits a fixed settling time and then polls only the last sector it started. Each sector is 64 KB, which is 32768 words, so the base word address of sector `s` is `s × 0x8000`. The program timeout, the erase timeout and the settling time are all counted in clock cycles.

The flash bus is simple. A write is one cycle with `fl_we` high. A read is one cycle with `fl_re` high, and the flash answers on `fl_rdata` in the following cycle.

Top module: `nor_flash_sequencer`

## Requirements
- R1: A request is taken when `req_valid` is high while `busy` is low. `busy` goes high in the cycle after acceptance and stays high through the `done` cycle. A request presented while `busy` is high has no effect, and the bus stays quiet whenever `busy` is low.
- R2: A program request first reads the target word. If (current AND data) differs from data, the request ends with status 2 and the block performs no write.
- R3: An accepted program writes 0x00AA to word 0x555, 0x0055 to word 0x2AA and 0x00A0 to word 0x555, then writes the data word to the target address. The bus never reads and writes in the same cycle.
- R4: After the data write, the block re-reads the target address. Completion comes when bit 7 read back equals bit 7 of the data. The request then ends with status 0 and no further write.
- R5: If PROG_TO polling cycles pass without a match, the block writes 0x00F0 to the target address and ends with status 1.
- R6: An erase request is rejected with status 3 and no bus activity if the first index is negative, if first > last, or if last ≥ NSECT.
- R7: An accepted erase writes 0x00AA to word 0x555, 0x0055 to word 0x2AA, 0x0080 to word 0x555, 0x00AA to word 0x555 and 0x0055 to word 0x2AA. It then writes 0x0030 to the base (index × 0x8000) of each unprotected sector in the range, in ascending order.
- R8: After the last sector command, at least ERASE_WAIT cycles pass before the first poll read. Polls read only the base of the last sector commanded. When bit 7 reads 1, the block writes 0x00F0 to word 0 and ends with status 0.
- R9: If every sector in the range is protected, the block performs no poll read. It writes 0x00F0 to word 0 and ends with status 0.
- R10: If ERASE_TO polling cycles pass without bit 7 set, the erase ends with status 1 and no reset write.
- R11: `done` is a single-cycle pulse, and `status` is valid during it: 0 success, 1 timeout, 2 not erased, 3 range rejected. After reset, `busy`, `done` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_erase | input | 1 | 1 = erase request, 0 = program request |
| req_addr | input | AW | Program target word address |
| req_data | input | 16 | Program data word |
| req_first | input | IW | First sector index (signed) |
| req_last | input | IW | Last sector index (signed) |
| protect | input | NSECT | Per-sector protection bits |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code, valid with done |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 16 | Flash read data, valid the cycle after fl_re |

## Verification
The assertions take for granted that the flash answers every read exactly one cycle later. They also take for granted that `req_valid` is a clean level sampled only at clock edges, so that a rise of `busy` can be traced back to a request seen in the previous cycle. The bench's flash model answers with fixed one-cycle latency. It drives requests only at falling edges, and it sends its deliberate extra request only while the block is busy. The bench sweeps signed sector ranges that cross both ends of the valid span, every protection pattern, and nibble patterns of current and new data. In each case it predicts the exact write list, the read addresses and the result code arithmetically.

// File: rtl/nor_flash_sequencer.sv
module nor_flash_sequencer #(
  parameter int AW         = 22,
  parameter int NSECT      = 128,
  parameter int PROG_TO    = 20000,
  parameter int ERASE_TO   = 50000000,
  parameter int ERASE_WAIT = 50000,
  localparam int SW        = $clog2(NSECT),
  localparam int IW        = $clog2(NSECT) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_erase,
  input  logic [AW-1:0]        req_addr,
  input  logic [15:0]          req_data,
  input  logic signed [IW-1:0] req_first,
  input  logic signed [IW-1:0] req_last,
  input  logic [NSECT-1:0]     protect,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           status,
  output logic [AW-1:0]        fl_addr,
  output logic [15:0]          fl_wdata,
  output logic                 fl_we,
  output logic                 fl_re,
  input  logic [15:0]          fl_rdata
);
  localparam int SECT_W = 15;
  localparam int TMAX   = (ERASE_TO > PROG_TO) ? ((ERASE_TO > ERASE_WAIT) ? ERASE_TO : ERASE_WAIT)
                                               : ((PROG_TO > ERASE_WAIT) ? PROG_TO : ERASE_WAIT);
  localparam int TW     = $clog2(TMAX + 2) + 1;
  localparam logic [AW-1:0] A555 = AW'(12'h555);
  localparam logic [AW-1:0] A2AA = AW'(12'h2AA);
  localparam logic signed [IW-1:0] NSECT_S = IW'(NSECT);

  typedef enum logic [3:0] {S_IDLE, S_CHK_RD, S_CHK, S_CMD, S_SECT, S_WAIT,
                            S_POLL_RD, S_POLL, S_RST, S_DONE} state_t;

  state_t            state;
  logic [2:0]        step;
  logic              op_erase, hit;
  logic [AW-1:0]     addr_r, rst_addr;
  logic [15:0]       data_r;
  logic [SW-1:0]     sec, last_r, hit_sec;
  logic [NSECT-1:0]  prot_r;
  logic [TW-1:0]     timer;
  logic [1:0]        status_r;
  logic [AW-1:0]     sect_addr, poll_addr;
  logic              ready;

  assign sect_addr = AW'({sec, {SECT_W{1'b0}}});
  assign poll_addr = op_erase ? AW'({hit_sec, {SECT_W{1'b0}}}) : addr_r;
  assign ready     = op_erase ? fl_rdata[7] : (fl_rdata[7] == data_r[7]);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign status    = status_r;

  always_comb begin
    fl_we = 1'b0; fl_re = 1'b0; fl_addr = '0; fl_wdata = '0;
    case (state)
      S_CHK_RD, S_POLL_RD: begin fl_re = 1'b1; fl_addr = poll_addr; end
      S_CMD: begin
        fl_we = 1'b1;
        case (step)
          3'd0: begin fl_addr = A555; fl_wdata = 16'h00AA; end
          3'd1: begin fl_addr = A2AA; fl_wdata = 16'h0055; end
          3'd2: begin fl_addr = A555; fl_wdata = op_erase ? 16'h0080 : 16'h00A0; end
          3'd3: begin
            fl_addr  = op_erase ? A555 : addr_r;
            fl_wdata = op_erase ? 16'h00AA : data_r;
          end
          default: begin fl_addr = A2AA; fl_wdata = 16'h0055; end
        endcase
      end
      S_SECT: begin fl_we = !prot_r[sec]; fl_addr = sect_addr; fl_wdata = 16'h0030; end
      S_RST:  begin fl_we = 1'b1; fl_addr = rst_addr; fl_wdata = 16'h00F0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; step <= '0; op_erase <= 1'b0; hit <= 1'b0;
      addr_r <= '0; rst_addr <= '0; data_r <= '0; sec <= '0; last_r <= '0;
      hit_sec <= '0; prot_r <= '0; timer <= '0; status_r <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_erase <= req_erase; addr_r <= req_addr; data_r <= req_data;
          prot_r <= protect; step <= '0; timer <= '0; hit <= 1'b0;
          sec <= req_first[SW-1:0]; last_r <= req_last[SW-1:0];
          if (!req_erase) state <= S_CHK_RD;
          else if (req_first[IW-1] || req_first > req_last || req_last >= NSECT_S) begin
            status_r <= 2'd3; state <= S_DONE;
          end else state <= S_CMD;
        end
        S_CHK_RD: state <= S_CHK;
        S_CHK: if ((fl_rdata & data_r) != data_r) begin
          status_r <= 2'd2; state <= S_DONE;
        end else state <= S_CMD;
        S_CMD: begin
          step <= step + 3'd1;
          if (!op_erase && step == 3'd3) begin state <= S_POLL_RD; timer <= '0; end
          else if (op_erase && step == 3'd4) state <= S_SECT;
        end
        S_SECT: begin
          if (!prot_r[sec]) begin hit <= 1'b1; hit_sec <= sec; end
          if (sec == last_r) begin
            timer <= '0;
            if (hit || !prot_r[sec]) state <= S_WAIT;
            else begin rst_addr <= '0; status_r <= 2'd0; state <= S_RST; end
          end else sec <= sec + 1'b1;
        end
        S_WAIT: begin
          timer <= timer + 1'b1;
          if (timer >= TW'(ERASE_WAIT - 1)) begin timer <= '0; state <= S_POLL_RD; end
        end
        S_POLL_RD: begin timer <= timer + 1'b1; state <= S_POLL; end
        S_POLL: begin
          timer <= timer + 1'b1;
          if (ready) begin
            status_r <= 2'd0; rst_addr <= '0;
            state <= op_erase ? S_RST : S_DONE;
          end else if (timer >= (op_erase ? TW'(ERASE_TO) : TW'(PROG_TO))) begin
            status_r <= 2'd1; rst_addr <= addr_r;
            state <= op_erase ? S_DONE : S_RST;
          end else state <= S_POLL_RD;
        end
        S_RST:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fl_we && fl_re)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!fl_we && !fl_re)); // R1
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid)); // R1
  AST_REJECT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) (done && status == 2'd3) |-> $past(!busy)); // R6
  AST_NOT_ERASED_READ: assert property (@(posedge clk) disable iff (!rst_n) (done && status == 2'd2) |-> $past(fl_re, 2)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
endmodule

// File: tb/tb_nor_flash_sequencer.sv
module tb_nor_flash_sequencer;
  localparam int AW = 17, NSECT = 4, PT = 40, ET = 60, EW = 12, IW = 4;
  localparam int BIG = 1000000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_erase, busy, done, fl_we, fl_re;
  logic [AW-1:0] req_addr, fl_addr;
  logic [15:0] req_data, fl_wdata, fl_rdata;
  logic signed [IW-1:0] req_first, req_last;
  logic [NSECT-1:0] protect;
  logic [1:0] status;

  nor_flash_sequencer #(.AW(AW), .NSECT(NSECT), .PROG_TO(PT), .ERASE_TO(ET), .ERASE_WAIT(EW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase), .req_addr(req_addr),
    .req_data(req_data), .req_first(req_first), .req_last(req_last), .protect(protect),
    .busy(busy), .done(done), .status(status), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata));

  int cyc = 0, nvec = 0, nfail = 0;
  int nw, nr, nrd, m_busy;
  bit m_prog;
  logic [15:0] m_cur, m_data;
  logic [AW-1:0] wa[64], ra[64];
  logic [15:0] wd[64];
  int wt[64], rt[64];
  logic [AW-1:0] ea[16];
  logic [15:0] ed[16];
  int ne;

  always @(posedge clk) begin
    logic [15:0] v;
    int k;
    if (fl_we && nw < 64) begin wa[nw] = fl_addr; wd[nw] = fl_wdata; wt[nw] = cyc; nw++; end
    if (fl_re) begin
      if (m_prog && nrd == 0) v = m_cur;
      else begin
        k = nrd - (m_prog ? 1 : 0);
        if (k < m_busy) v = m_prog ? {8'h00, ~m_data[7], 7'h00} : 16'h0000;
        else v = m_prog ? m_data : 16'hFFFF;
      end
      fl_rdata <= v;
      if (nr < 64) begin ra[nr] = fl_addr; rt[nr] = cyc; nr++; end
      nrd++;
    end
    cyc++;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nvec++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", r, act, exp); end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [15:0] d);
    ea[ne] = a; ed[ne] = d; ne++;
  endtask

  task automatic run(input bit inject);
    int n;
    @(negedge clk);
    nw = 0; nr = 0; nrd = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R1 busy after accept", busy, 1);
    n = 0;
    while (done !== 1'b1 && n < 3000) begin
      if (inject && n == 2) begin req_valid = 1'b1; req_erase = ~req_erase; req_addr = 17'h00555; end
      else req_valid = 1'b0;
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    if (n >= 3000) chk(1'b0, "R11 op watchdog", n, 0);
  endtask

  task automatic check_writes(input string r);
    chk(nw == ne, {r, " write count"}, nw, ne);
    for (int i = 0; i < ne && i < nw; i++)
      chk(wa[i] == ea[i] && wd[i] == ed[i], {r, " write"}, {wa[i], wd[i]}, {ea[i], ed[i]});
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [15:0] d, input logic [15:0] cur,
                         input int bsy, input bit inject);
    logic [1:0] est;
    m_prog = 1'b1; m_cur = cur; m_data = d; m_busy = bsy;
    req_erase = 1'b0; req_addr = a; req_data = d;
    ne = 0;
    if ((cur & d) != d) est = 2'd2;
    else begin
      push(AW'(12'h555), 16'h00AA); push(AW'(12'h2AA), 16'h0055);
      push(AW'(12'h555), 16'h00A0); push(a, d);
      if (bsy >= BIG) begin push(a, 16'h00F0); est = 2'd1; end
      else est = 2'd0;
    end
    run(inject);
    chk(status == est, (est == 2) ? "R2 not-erased status" : (est == 1) ? "R5 timeout status" : "R4 program status",
        status, est);
    check_writes(est == 2 ? "R2" : "R3");
    if (est == 2) chk(nr == 1, "R2 single read", nr, 1);
    else if (est == 0) chk(nr == bsy + 2, "R4 poll read count", nr, bsy + 2);
    else if (nw >= 5) chk(wt[4] - wt[3] >= PT, "R5 timeout delay", wt[4] - wt[3], PT);
    for (int i = 0; i < nr; i++) chk(ra[i] == a, "R4 read address", ra[i], a);
    @(negedge clk);
    chk(!busy && !done, "R11 done one cycle", {busy, done}, 0);
  endtask

  task automatic do_erase(input int f, input int l, input logic [NSECT-1:0] p, input int bsy,
                          input bit inject);
    logic [1:0] est;
    int lastS, lastIdx;
    m_prog = 1'b0; m_busy = bsy;
    req_erase = 1'b1; req_first = IW'(f); req_last = IW'(l); protect = p;
    ne = 0; lastS = -1; lastIdx = -1;
    if (f < 0 || f > l || l >= NSECT) est = 2'd3;
    else begin
      push(AW'(12'h555), 16'h00AA); push(AW'(12'h2AA), 16'h0055); push(AW'(12'h555), 16'h0080);
      push(AW'(12'h555), 16'h00AA); push(AW'(12'h2AA), 16'h0055);
      for (int s = f; s <= l; s++)
        if (!p[s]) begin push(AW'(s) << 15, 16'h0030); lastS = s; lastIdx = ne - 1; end
      if (lastS >= 0 && bsy >= BIG) est = 2'd1;
      else begin push('0, 16'h00F0); est = 2'd0; end
    end
    run(inject);
    chk(status == est, (est == 3) ? "R6 reject status" : (est == 1) ? "R10 erase timeout status" : "R8 erase status",
        status, est);
    check_writes(est == 3 ? "R6" : "R7");
    if (est == 3 || lastS < 0) chk(nr == 0, est == 3 ? "R6 no reads" : "R9 no poll", nr, 0);
    else begin
      if (est == 0) chk(nr == bsy + 1, "R8 poll count", nr, bsy + 1);
      for (int i = 0; i < nr; i++) chk(ra[i] == (AW'(lastS) << 15), "R8 poll address", ra[i], AW'(lastS) << 15);
      if (nr > 0 && lastIdx < nw) chk(rt[0] - wt[lastIdx] > EW, "R8 settle wait", rt[0] - wt[lastIdx], EW);
    end
    @(negedge clk);
    chk(!busy && !done, "R11 done one cycle", {busy, done}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R11 global watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    nw = 0; nr = 0; nrd = 0; m_busy = 0; m_prog = 1'b0; m_cur = '0; m_data = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_erase = 1'b0; req_addr = '0; req_data = '0;
    req_first = '0; req_last = '0; protect = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fl_we && !fl_re, "R11 reset state", {busy, done, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 16; c++)
      for (int d = 0; d < 16; d++)
        do_prog(AW'((c * 37 + d * 1001) % (1 << AW)), {4'hA, 4'(d), (d % 2 == 1) ? 8'hC3 : 8'h3C},
                {4'hF, 4'(c), 8'hFF}, (c + d) % 4, (c == 3 && d == 5));
    do_prog(17'h1ABCD, 16'h1234, 16'hFFFF, BIG, 1'b0);   // R5
    do_prog(17'h00F00, 16'h00F0, 16'hFFFF, BIG, 1'b1);   // R5 with ignored request, R1

    for (int f = -2; f <= 5; f++)
      for (int l = -2; l <= 5; l++)
        for (int p = 0; p < 16; p++)
          do_erase(f, l, 4'(p), (f + l + p) & 3, (f == 0 && l == 3 && p == 5));
    do_erase(0, 3, 4'b0101, BIG, 1'b0);  // R10
    do_erase(1, 1, 4'b0000, BIG, 1'b1);  // R10 with ignored request

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule